// File: doc/BRIEF.md
# Self-Posting Core Performance Counter Unit

This block sits beside one processor core and keeps four 64-bit event counters. Counter 0 counts core cycles and counter 1 counts retired instructions. Counters 2 and 3 each take one of 128 event lines, chosen by a 7-bit select. The unit never interrupts the core. Every result reaches software through plain 64-bit writes that the unit issues on its own, one beat at a time, over a request/acknowledge port. Software can then read those memory words whenever it likes.

A start pulse clears the counters and latches the operating mode. A stop pulse freezes counting and posting. In periodic mode, a down-counting timer reloads from a 32-bit period value, and each time it expires the four counts are posted as one block at the programmed base address. In sampling mode, a 32-bit sampler is preloaded from a reload value and advances on every cycle pulse. Each time it overflows, a four-word record holding the current program counter and the counts is posted into a 256-slot ring that starts at the base address.

Top module: `perf_post_unit`

## Requirements
- R1: While running, counter 0 advances by one on each clock with `cyc_pulse_i` high and counter 1 on each clock with `inst_pulse_i` high. A start pulse clears all four counters to zero.
- R2: In periodic mode (`trace_mode_i`=0 at start), counter 2 counts `evt_a_i[sel_a_i]` and counter 3 counts `evt_b_i[sel_b_i]`.
- R3: In periodic mode the timer is loaded with `period_i` at start. Its first expiry is at clock edge start+P+1, and later expiries follow every P+1 edges. Each expiry posts the counter values held just before that edge, so with constant pulses the first post carries P.
- R4: A periodic post is four beats with address base+8*i and data equal to counter i, for i = 0,1,2,3 in that order.
- R5: In sampling mode the sampler is loaded with `reload_i` at start and advances on each cycle pulse. A cycle pulse that arrives while it holds all ones causes an overflow and reloads it. With reload 2^32-N, overflows occur every N cycle pulses, and the first record carries N-1 cycles.
- R6: A sampling record is four beats: word 0 is `pc_i` at the overflow edge, then counters 0, 1 and 2. In sampling mode counters 2 and 3 count cycle pulses whatever the selects and event lines hold.
- R7: Sampling record s (s = 0..255) is written at base + 32*s + 8*i. After slot 255 the next record goes to slot 0. A start resets the slot to 0.
- R8: A post trigger that arrives while a post is still in progress writes nothing extra and sets `dropped_o`. `dropped_o` stays set until the next start.
- R9: A beat keeps `mem_req_o`, `mem_addr_o` and `mem_data_o` unchanged until `mem_ack_i`. Counting and the timer or sampler keep running while the unit waits for the acknowledge.
- R10: Nothing is counted or posted before start or after stop. A post already in progress at stop still completes. The mode is latched at start, so later changes on `trace_mode_i` have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | start pulse: clear counters and latch the mode |
| stop_i | input | 1 | stop pulse: freeze counting and posting |
| cyc_pulse_i | input | 1 | core cycle event |
| inst_pulse_i | input | 1 | instruction-retired event |
| evt_a_i | input | EVT_N (128) | event lines for counter 2 |
| evt_b_i | input | EVT_N (128) | event lines for counter 3 |
| sel_a_i | input | 7 | event select for counter 2 |
| sel_b_i | input | 7 | event select for counter 3 |
| pc_i | input | 64 | current program counter |
| base_addr_i | input | 64 | destination base address |
| trace_mode_i | input | 1 | 0 = periodic, 1 = sampling (latched at start) |
| period_i | input | PER_W (32) | periodic timer reload value |
| reload_i | input | SAMP_W (32) | sampler preload value |
| mem_req_o | output | 1 | write beat valid |
| mem_addr_o | output | 64 | write beat byte address |
| mem_data_o | output | 64 | write beat data |
| mem_ack_i | input | 1 | write beat accepted |
| dropped_o | output | 1 | sticky flag: a trigger was lost |

## Verification
A timer or sampler that is off by one shows up in the very first posted record, whose counts move away from P or N-1 as soon as the burst appears. A wrong ring slot or a wrong address step is visible on the address bus within the same burst, or at the 257th record for the wrap. A lost or stuck busy flag shows at the ports within one trigger interval, as a missing or extra burst, a beat that changes without an acknowledge, or `dropped_o` set or left clear at the wrong time.

// File: rtl/ppu_pkg.sv
package ppu_pkg;
  localparam int WORD_W     = 64;
  localparam int N_CNT      = 4;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int REC_BYTES  = N_CNT * WORD_BYTES;
  localparam int BEAT_W     = $clog2(N_CNT);

  typedef logic [WORD_W-1:0]             word_t;
  typedef logic [N_CNT-1:0][WORD_W-1:0]  cnt_vec_t;

  // First byte of a record: periodic posts always start at base,
  // sampling records step through the ring one record per slot.
  function automatic word_t rec_start(input word_t base, input logic trace,
                                      input word_t slot);
    return base + (trace ? slot * word_t'(REC_BYTES) : '0);
  endfunction

  function automatic word_t beat_addr(input word_t rec, input logic [BEAT_W-1:0] beat);
    return rec + word_t'(beat) * word_t'(WORD_BYTES);
  endfunction

  // Word layout of one record.
  function automatic word_t rec_word(input logic trace, input cnt_vec_t cnt,
                                     input word_t pc, input logic [BEAT_W-1:0] idx);
    if (!trace) return cnt[idx];
    if (idx == '0) return pc;
    return cnt[idx - 1'b1];
  endfunction
endpackage

// File: rtl/ppu_counters.sv
module ppu_counters import ppu_pkg::*; #(
  parameter int EVT_N = 128,
  parameter int SEL_W = $clog2(EVT_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             trace_i,
  input  logic             cyc_i,
  input  logic             inst_i,
  input  logic [EVT_N-1:0] evt_a_i,
  input  logic [EVT_N-1:0] evt_b_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output cnt_vec_t         cnt_o
);
  localparam int N_PROG = N_CNT - 2;

  logic [N_CNT-1:0]            inc;
  logic [N_PROG-1:0][EVT_N-1:0] evt_lines;
  logic [N_PROG-1:0][SEL_W-1:0] evt_sel;
  cnt_vec_t                    cnt_q;

  assign evt_lines = {evt_b_i, evt_a_i};
  assign evt_sel   = {sel_b_i, sel_a_i};
  assign inc[0]    = cyc_i;
  assign inc[1]    = inst_i;

  // Programmable counters: sampling mode forces them onto cycles.
  for (genvar gi = 0; gi < N_PROG; gi++) begin : g_prog
    assign inc[2+gi] = trace_i ? cyc_i : evt_lines[gi][evt_sel[gi]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      for (int i = 0; i < N_CNT; i++)
        if (inc[i]) cnt_q[i] <= cnt_q[i] + word_t'(1);
    end
  end

  assign cnt_o = cnt_q;

  // R10: counts are frozen while stopped
  p_cnt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !start_i) |=> $stable(cnt_o));
  // R1: start leaves every counter at zero
  p_cnt_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_o == '0));
endmodule

// File: rtl/ppu_trigger.sv
module ppu_trigger #(
  parameter int PER_W  = 32,
  parameter int SAMP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              trace_i,
  input  logic              cyc_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [SAMP_W-1:0] reload_i,
  output logic              fire_o
);
  localparam logic [SAMP_W-1:0] SAMP_TOP = '1;

  logic [PER_W-1:0]  timer_q;
  logic [SAMP_W-1:0] samp_q;
  logic              acc_fire;
  logic              tr_fire;

  assign acc_fire = run_i && !start_i && !trace_i && (timer_q == '0);
  assign tr_fire  = run_i && !start_i && trace_i && cyc_i && (samp_q == SAMP_TOP);
  assign fire_o   = acc_fire || tr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      samp_q  <= '0;
    end else if (start_i) begin
      timer_q <= period_i;
      samp_q  <= reload_i;
    end else if (run_i) begin
      if (!trace_i)
        timer_q <= (timer_q == '0) ? period_i : timer_q - 1'b1;
      if (trace_i && cyc_i)
        samp_q <= (samp_q == SAMP_TOP) ? reload_i : samp_q + 1'b1;
    end
  end

  // R3: an expiry reloads the period
  p_timer_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (timer_q == $past(period_i)));
  // R5: an overflow reloads the sampler
  p_samp_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tr_fire |=> (samp_q == $past(reload_i)));
  // R10: stopped unit raises no trigger
  p_no_fire_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !fire_o);
endmodule

// File: rtl/ppu_poster.sv
module ppu_poster import ppu_pkg::*; #(
  parameter int RING_N = 256,
  parameter int SLOT_W = $clog2(RING_N)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     fire_i,
  input  logic     trace_i,
  input  word_t    base_i,
  input  word_t    pc_i,
  input  cnt_vec_t cnt_i,
  input  logic     ack_i,
  output logic     req_o,
  output word_t    addr_o,
  output word_t    data_o,
  output logic     dropped_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(N_CNT - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(RING_N - 1);

  cnt_vec_t          snap_q;
  cnt_vec_t          snap_d;
  logic [BEAT_W-1:0] beat_q;
  logic [SLOT_W-1:0] slot_q;
  word_t             rec_q;
  logic              busy_q;
  logic              dropped_q;
  logic              take;
  logic              drop;
  logic              beat_done;
  logic              rec_done;

  assign take      = fire_i && !busy_q;
  assign drop      = fire_i && busy_q;
  assign beat_done = busy_q && ack_i;
  assign rec_done  = beat_done && (beat_q == LAST_BEAT);

  always_comb begin
    for (int i = 0; i < N_CNT; i++)
      snap_d[i] = rec_word(trace_i, cnt_i, pc_i, BEAT_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      beat_q <= '0;
      rec_q  <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      snap_q <= snap_d;
      beat_q <= '0;
      rec_q  <= rec_start(base_i, trace_i, WORD_W'(slot_q));
      busy_q <= 1'b1;
    end else if (beat_done) begin
      beat_q <= beat_q + 1'b1;
      if (rec_done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= '0;
      dropped_q <= 1'b0;
    end else if (start_i) begin
      slot_q    <= '0;
      dropped_q <= 1'b0;
    end else begin
      if (drop) dropped_q <= 1'b1;
      if (rec_done && trace_i)
        slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  assign req_o     = busy_q;
  assign addr_o    = beat_addr(rec_q, beat_q);
  assign data_o    = snap_q[beat_q];
  assign dropped_o = dropped_q;

  // R9: beat held until acknowledged
  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));
  // R8: lost-trigger flag is sticky until start
  p_drop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped_o && !start_i) |=> dropped_o);
  // R7: ring wraps to slot 0
  p_slot_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && trace_i && !start_i && slot_q == LAST_SLOT) |=> (slot_q == '0));
  // R4: next beat steps one word
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !rec_done && !take) |=> (addr_o == $past(addr_o) + word_t'(WORD_BYTES)));
endmodule

// File: rtl/perf_post_unit.sv
module perf_post_unit import ppu_pkg::*; #(
  parameter int EVT_N  = 128,
  parameter int SEL_W  = $clog2(EVT_N),
  parameter int PER_W  = 32,
  parameter int SAMP_W = 32,
  parameter int RING_N = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cyc_pulse_i,
  input  logic              inst_pulse_i,
  input  logic [EVT_N-1:0]  evt_a_i,
  input  logic [EVT_N-1:0]  evt_b_i,
  input  logic [SEL_W-1:0]  sel_a_i,
  input  logic [SEL_W-1:0]  sel_b_i,
  input  logic [63:0]       pc_i,
  input  logic [63:0]       base_addr_i,
  input  logic              trace_mode_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [SAMP_W-1:0] reload_i,
  output logic              mem_req_o,
  output logic [63:0]       mem_addr_o,
  output logic [63:0]       mem_data_o,
  input  logic              mem_ack_i,
  output logic              dropped_o
);
  logic     run_q;
  logic     trace_q;
  logic     fire;
  cnt_vec_t cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      trace_q <= 1'b0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      trace_q <= trace_mode_i;
    end else if (stop_i) begin
      run_q   <= 1'b0;
    end
  end

  ppu_counters #(.EVT_N(EVT_N), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_q), .trace_i(trace_q),
    .cyc_i(cyc_pulse_i), .inst_i(inst_pulse_i), .evt_a_i(evt_a_i), .evt_b_i(evt_b_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .cnt_o(cnt)
  );

  ppu_trigger #(.PER_W(PER_W), .SAMP_W(SAMP_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_q), .trace_i(trace_q),
    .cyc_i(cyc_pulse_i), .period_i(period_i), .reload_i(reload_i), .fire_o(fire)
  );

  ppu_poster #(.RING_N(RING_N)) u_post (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fire_i(fire), .trace_i(trace_q),
    .base_i(base_addr_i), .pc_i(pc_i), .cnt_i(cnt), .ack_i(mem_ack_i),
    .req_o(mem_req_o), .addr_o(mem_addr_o), .data_o(mem_data_o), .dropped_o(dropped_o)
  );

  // R10: a stopped, idle unit starts no write
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !mem_req_o) |=> !mem_req_o);
endmodule

// File: tb/perf_post_unit_tb.sv
module perf_post_unit_tb;
  localparam int CLK_P = 10;
  localparam int LOG_N = 1100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 0, stop_i = 0, cyc_pulse_i = 0, inst_pulse_i = 0;
  logic [127:0] evt_a_i = '0, evt_b_i = '0;
  logic [6:0]   sel_a_i = '0, sel_b_i = '0;
  logic [63:0]  pc_i = '0, base_addr_i = '0;
  logic         trace_mode_i = 0;
  logic [31:0]  period_i = '0, reload_i = '0;
  logic         mem_ack_i = 0;
  logic         mem_req_o, dropped_o;
  logic [63:0]  mem_addr_o, mem_data_o;

  always #(CLK_P/2) clk = ~clk;

  perf_post_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cyc_pulse_i(cyc_pulse_i), .inst_pulse_i(inst_pulse_i), .evt_a_i(evt_a_i),
    .evt_b_i(evt_b_i), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .pc_i(pc_i),
    .base_addr_i(base_addr_i), .trace_mode_i(trace_mode_i), .period_i(period_i),
    .reload_i(reload_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .mem_ack_i(mem_ack_i), .dropped_o(dropped_o)
  );

  int n_chk = 0, n_fail = 0, log_n = 0;
  logic [63:0] log_addr [LOG_N];
  logic [63:0] log_data [LOG_N];

  // beat log: a beat is accepted when req and ack are both high
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_req_o && mem_ack_i && log_n < LOG_N) begin
      log_addr[log_n] = mem_addr_o;
      log_data[log_n] = mem_data_o;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic mode);
    @(negedge clk);
    trace_mode_i = mode;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    trace_mode_i = ~mode;  // R10: mode must stay latched
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask

  task automatic wait_beats(input int n);
    for (int t = 0; t < 6000 && log_n < n; t++) @(negedge clk);
  endtask

  typedef struct packed {
    logic        mode;
    logic [31:0] prm;
    logic [6:0]  sa;
    logic [6:0]  sb;
    logic        ea;
    logic        eb;
    logic        inst;
    logic [63:0] pc;
    logic [63:0] base;
    logic [63:0] w0;
    logic [63:0] w1;
    logic [63:0] w2;
    logic [63:0] w3;
  } vec_t;

  // periodic: words P,P*inst,P*ea,P*eb ; sampling (reload 2^32-N): pc,N-1,(N-1)*inst,N-1
  localparam vec_t VEC [6] = '{
    '{1'b0, 32'd5,  7'd0,   7'd127, 1'b1, 1'b0, 1'b1, 64'h0, 64'h1000, 64'd5, 64'd5, 64'd5, 64'd0},
    '{1'b0, 32'd12, 7'd64,  7'd3,   1'b0, 1'b1, 1'b0, 64'h0, 64'h2000, 64'd12, 64'd0, 64'd0, 64'd12},
    '{1'b0, 32'd1,  7'd127, 7'd0,   1'b1, 1'b1, 1'b1, 64'h0, 64'h3000, 64'd1, 64'd1, 64'd1, 64'd1},
    '{1'b1, 32'hFFFF_FFEC, 7'd9, 7'd9, 1'b0, 1'b0, 1'b1, 64'h0000_7FFF_1234_5678, 64'h4000,
      64'h0000_7FFF_1234_5678, 64'd19, 64'd19, 64'd19},
    '{1'b1, 32'hFFFF_FFF9, 7'd1, 7'd2, 1'b0, 1'b0, 1'b0, 64'hC000_0000_0000_0ABC, 64'h5000,
      64'hC000_0000_0000_0ABC, 64'd6, 64'd0, 64'd6},
    '{1'b0, 32'd0,  7'd5,   7'd6,   1'b1, 1'b1, 1'b1, 64'h0, 64'h6000, 64'd0, 64'd0, 64'd0, 64'd0}
  };

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=%h expected=%h", 64'd0, 64'd1);
    summary();
  end

  initial begin
    logic [63:0] a0, d0, exp_w;
    cycles(3);
    rst_n = 1;
    cyc_pulse_i = 1;
    // reset state and quiet before start (R10)
    @(negedge clk);
    chk(mem_req_o == 0, "R10 reset req", 64'(mem_req_o), 0);
    chk(dropped_o == 0, "R8 reset dropped", 64'(dropped_o), 0);
    cycles(20);
    chk(log_n == 0 && mem_req_o == 0, "R10 no post before start", 64'(log_n), 0);

    // table walk: R1..R6 first record contents and addresses
    mem_ack_i = 1;
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      period_i = VEC[v].prm; reload_i = VEC[v].prm;
      sel_a_i = VEC[v].sa; sel_b_i = VEC[v].sb;
      evt_a_i = VEC[v].ea ? (128'b1 << VEC[v].sa) : ~(128'b1 << VEC[v].sa);
      evt_b_i = VEC[v].eb ? (128'b1 << VEC[v].sb) : ~(128'b1 << VEC[v].sb);
      inst_pulse_i = VEC[v].inst; pc_i = VEC[v].pc; base_addr_i = VEC[v].base;
      log_n = 0;
      pulse_start(VEC[v].mode);
      wait_beats(4);
      for (int j = 0; j < 4; j++) begin
        case (j)
          0: exp_w = VEC[v].w0;
          1: exp_w = VEC[v].w1;
          2: exp_w = VEC[v].w2;
          default: exp_w = VEC[v].w3;
        endcase
        chk(log_data[j] == exp_w,
            $sformatf("R1 R2 R3 R5 R6 vec%0d word%0d data", v, j), log_data[j], exp_w);
        chk(log_addr[j] == VEC[v].base + 64'(8*j),
            $sformatf("R4 R7 vec%0d word%0d addr", v, j), log_addr[j], VEC[v].base + 64'(8*j));
      end
      pulse_stop();
      cycles(8);
    end

    // R9: beat held without ack, counting continues meanwhile
    mem_ack_i = 0; period_i = 10; inst_pulse_i = 1; base_addr_i = 64'h8000;
    evt_a_i = '1; evt_b_i = '1;
    log_n = 0;
    pulse_start(1'b0);
    for (int t = 0; t < 100 && !mem_req_o; t++) @(negedge clk);
    a0 = mem_addr_o; d0 = mem_data_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_req_o && mem_addr_o == a0 && mem_data_o == d0, "R9 beat held without ack", mem_data_o, d0);
    end
    mem_ack_i = 1;
    wait_beats(8);
    chk(log_data[0] == 64'd10, "R3 first period count", log_data[0], 64'd10);
    chk(log_data[4] == 64'd21, "R9 second period count after stall", log_data[4], 64'd21);
    chk(log_addr[4] == 64'h8000, "R4 second post at base", log_addr[4], 64'h8000);
    chk(dropped_o == 0, "R8 no drop when burst fits", 64'(dropped_o), 0);

    // R10: stop halts posting
    pulse_stop();
    cycles(8);
    log_n = 0;
    cycles(50);
    chk(log_n == 0 && mem_req_o == 0, "R10 nothing posted after stop", 64'(log_n), 0);

    // R8: overflow while a record is pending
    mem_ack_i = 0; reload_i = 32'hFFFF_FFFC; pc_i = 64'h55AA; base_addr_i = 64'h9000;
    log_n = 0;
    pulse_start(1'b1);
    cycles(20);
    chk(dropped_o == 1, "R8 dropped set on overlap", 64'(dropped_o), 1);
    mem_ack_i = 1;
    wait_beats(4);
    chk(log_data[0] == 64'h55AA && log_data[1] == 64'd3, "R8 first record intact", log_data[1], 64'd3);
    pulse_stop();
    cycles(8);
    chk((log_n % 4) == 0, "R8 only whole records written", 64'(log_n), 64'(((log_n + 3) / 4) * 4));
    chk(dropped_o == 1, "R8 dropped sticky after stop", 64'(dropped_o), 1);
    pulse_start(1'b0);
    chk(dropped_o == 0, "R8 dropped cleared by start", 64'(dropped_o), 0);
    pulse_stop();
    cycles(8);

    // R7: ring wrap after 256 records
    reload_i = 32'hFFFF_FFF8; base_addr_i = 64'h10_0000;
    log_n = 0;
    pulse_start(1'b1);
    wait_beats(1028);
    chk(log_addr[1020] == 64'h10_0000 + 64'd8160, "R7 slot 255 addr", log_addr[1020], 64'h10_0000 + 64'd8160);
    chk(log_addr[1024] == 64'h10_0000, "R7 wrap to base", log_addr[1024], 64'h10_0000);
    chk(log_addr[1027] == 64'h10_0018, "R7 wrap last word", log_addr[1027], 64'h10_0018);
    chk(log_data[1025] == 64'd2055, "R5 record 257 cycles", log_data[1025], 64'd2055);
    chk(dropped_o == 0, "R8 no drop in ring run", 64'(dropped_o), 0);
    pulse_stop();
    cycles(8);
    summary();
  end
endmodule